// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns a stream of parallel audio words into a serial bit stream on one data line. The bit clock and the frame sync both come from outside. The block samples them with its own system clock, so the bit clock must be well below the system clock rate. A frame begins on the bit-clock period in which the frame sync is first seen high. Each frame holds a first phase and, when dual-phase mode is on, a second phase. Each phase has its own word length and its own word count, and words go out MSB first.

Words come from a valid/ready port, one word per slot. Bits 31:0 carry the word, and a short word uses only its low bits. The data delay setting gives two timings. With delay 0, the first bit leaves in the sync period itself. With delay 1, that period stays blank and the first bit leaves in the next one. A frame sync that arrives in the middle of a frame can be ignored, or it can raise a sticky error flag and restart the frame. A transmitter enable input acts as the reset-release. While it is low, the line stays quiet, no words are taken, and both flags clear.

The controller is a four-state machine:
- `ST_IDLE`: the transmitter is held in reset.
- `ST_WAIT`: waiting for a frame sync.
- `ST_DELAY`: the one blank bit period of delay-1 mode.
- `ST_SHIFT`: bits of the frame are being shifted out.

Its transitions:
- IDLE→WAIT when the enable is high.
- WAIT→SHIFT on a sync with delay 0.
- WAIT→DELAY on a sync with delay 1.
- DELAY→SHIFT on the next launch edge.
- SHIFT→WAIT after the last bit of the last phase.
- SHIFT→SHIFT or SHIFT→DELAY when a sync restarts the frame.
- Any state returns to IDLE when the enable falls.

Top module: `serial_audio_tx`

## Requirements
- R1: The word length code maps as 0=8, 1=12, 2=16, 3=20, 4=24 bits, and 5 (or 6, 7) = 32 bits. Each word goes out MSB first, taken from the low bits of `din`.
- R2: The first phase carries `wcnt_a`+1 words of length `wlen_a`, sent back to back.
- R3: When `dual_phase` is 1, a second phase of `wcnt_b`+1 words of length `wlen_b` follows the first phase within the same frame.
- R4: With `data_delay`=0, the first data bit appears in the bit period whose launch edge sees the sync. With `data_delay`=1, that period outputs 0 and the first bit appears one period later.
- R5: A sync is a launch edge that sees `fsync` high after it was low at the previous launch edge. A sync starts a frame without error in `ST_WAIT`, or on the launch edge just after the last bit of a frame. Outside frames, `sdo` is 0.
- R6: With `fs_ignore`=1, a sync inside a frame has no effect: the frame continues bit for bit and `sync_err` stays 0.
- R7: With `fs_ignore`=0, a sync inside a frame sets `sync_err` and restarts the frame. `sync_err` stays 1 until `tx_en` is 0.
- R8: While `tx_en` is 0, `sdo` is 0, `din_ready` is 0 and no word is consumed, even with syncs and valid data present.
- R9: With `clk_pol`=0, data changes only on rising `sclk` edges. With `clk_pol`=1, data changes only on falling `sclk` edges.
- R10: If `din_valid` is 0 when a word slot starts, the previously sent word is repeated and `underrun` is set. `underrun` clears only when `tx_en` is 0.
- R11: `din_ready` is high only in the system-clock cycle of a launch edge that starts a word slot. Exactly one word is consumed per slot.
- R12: After reset, `sdo`, `din_ready`, `sync_err` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, active high |
| tx_en | input | 1 | Transmitter reset-release; 0 holds the block idle |
| clk_pol | input | 1 | Launch edge select: 0 rising, 1 falling |
| data_delay | input | 1 | Bit periods from sync to first data bit (0 or 1) |
| fs_ignore | input | 1 | Disregard syncs that arrive inside a frame |
| dual_phase | input | 1 | Enable the second phase |
| wlen_a | input | 3 | Word length code, first phase |
| wcnt_a | input | CNT_W | Words minus one, first phase |
| wlen_b | input | 3 | Word length code, second phase |
| wcnt_b | input | CNT_W | Words minus one, second phase |
| din | input | 32 | Parallel word in |
| din_valid | input | 1 | Word on din is valid |
| din_ready | output | 1 | Word taken this cycle |
| sdo | output | 1 | Serial data out |
| sync_err | output | 1 | Sticky unexpected-sync flag |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
The bench drives random frame shapes and words. It mixes lengths of 8 to 32 bits, one or two phases, both delays and gaps of zero to two periods. A back-to-back sync exercises the frame-end path. A design that failed to treat that sync as a start, or that miscounted a phase, would misplace every later bit.

Directed cases cover the hard spots:
- A sync inside a frame, under both settings of the ignore bit. A wrong design would either break the frame while ignoring, or miss the error flag.
- A missing word. A wrong design would send stale or zero bits in its place, or lose the flag.
- The falling-edge polarity. A wrong design would change data on the wrong edge.
- A disabled transmitter fed syncs and valid data. A wrong design would consume words or toggle the line.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DELAY,
        ST_SHIFT
    } tx_state_e;

    // Word length code to bit count
    function automatic logic [LEN_W-1:0] wl_decode(input logic [2:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sat_edge.sv
module sat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic fsync,
    input  logic clk_pol,
    output logic launch,
    output logic sync
);
    logic sclk_d;
    logic fs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (launch) begin
                fs_prev <= fsync;
            end
        end
    end

    // Launch edge: rising for polarity 0, falling for polarity 1
    always_comb begin
        if (clk_pol) begin
            launch = sclk_d & ~sclk;
        end else begin
            launch = ~sclk_d & sclk;
        end
        sync = launch & fsync & ~fs_prev;
    end

endmodule

// File: rtl/sat_frame_fsm.sv
module sat_frame_fsm
    import sat_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             launch,
    input  logic             sync,
    input  logic             delay1,
    input  logic             fs_ignore,
    input  logic             two_phase,
    input  logic [2:0]       wl_a,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [2:0]       wl_b,
    input  logic [CNT_W-1:0] cnt_b,
    output logic             load,
    output logic             shift,
    output logic             blank,
    output logic [LEN_W-1:0] load_len,
    output logic             sync_err
);
    localparam int BIT_W = $clog2(WORD_W);

    tx_state_e        state, nxt;
    logic [BIT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] word_cnt;
    logic             phase;
    logic             act, start, sel_first, adv_phase, err_set;
    logic             last_word, last_phase, frame_end;
    logic [LEN_W-1:0] cur_len;

    assign act        = tx_en & launch;
    assign cur_len    = phase ? wl_decode(wl_b) : wl_decode(wl_a);
    assign last_word  = (word_cnt == (phase ? cnt_b : cnt_a));
    assign last_phase = phase | ~two_phase;
    assign frame_end  = (bit_cnt == '0) & last_word & last_phase;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and per-launch controls
    always_comb begin
        nxt       = state;
        start     = 1'b0;
        load      = 1'b0;
        shift     = 1'b0;
        blank     = 1'b0;
        sel_first = 1'b0;
        adv_phase = 1'b0;
        err_set   = 1'b0;
        if (!tx_en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_WAIT;
                ST_WAIT: begin
                    if (act && sync) begin
                        start = 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (act) begin
                        if (sync && !fs_ignore) begin
                            err_set = 1'b1;
                            start   = 1'b1;
                        end else begin
                            load      = 1'b1;
                            sel_first = 1'b1;
                            nxt       = ST_SHIFT;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (act) begin
                        if (sync && (frame_end || !fs_ignore)) begin
                            start   = 1'b1;
                            err_set = ~frame_end;
                        end else if (bit_cnt != '0) begin
                            shift = 1'b1;
                        end else if (!last_word) begin
                            load = 1'b1;
                        end else if (!last_phase) begin
                            load      = 1'b1;
                            adv_phase = 1'b1;
                        end else begin
                            blank = 1'b1;
                            nxt   = ST_WAIT;
                        end
                    end
                end
            endcase
            if (start) begin
                if (delay1) begin
                    blank = 1'b1;
                    nxt   = ST_DELAY;
                end else begin
                    load      = 1'b1;
                    sel_first = 1'b1;
                    nxt       = ST_SHIFT;
                end
            end
        end
    end

    always_comb begin
        if (sel_first) begin
            load_len = wl_decode(wl_a);
        end else if (adv_phase) begin
            load_len = wl_decode(wl_b);
        end else begin
            load_len = cur_len;
        end
    end

    // Slot counters and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
            phase    <= 1'b0;
            sync_err <= 1'b0;
        end else if (!tx_en) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
            phase    <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            if (err_set) begin
                sync_err <= 1'b1;
            end
            if (load) begin
                bit_cnt <= BIT_W'(load_len - 6'd1);
                if (sel_first) begin
                    phase    <= 1'b0;
                    word_cnt <= '0;
                end else if (adv_phase) begin
                    phase    <= 1'b1;
                    word_cnt <= '0;
                end else begin
                    word_cnt <= word_cnt + 1'b1;
                end
            end else if (shift) begin
                bit_cnt <= bit_cnt - 1'b1;
            end
        end
    end

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && tx_en) |=> sync_err);
    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sync_err);
    p_one_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load, shift, blank}) <= 1);

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load,
    input  logic              shift,
    input  logic              blank,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [WORD_W-1:0] din,
    input  logic              din_valid,
    output logic              sdo,
    output logic              underrun
);
    logic [WORD_W-1:0] held;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] word_sel;
    logic [WORD_W-1:0] aligned;
    logic [LEN_W-1:0]  pad;

    assign word_sel = din_valid ? din : held;
    assign pad      = 6'd32 - load_len;
    assign aligned  = word_sel << pad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo      <= 1'b0;
            underrun <= 1'b0;
            held     <= '0;
            shreg    <= '0;
        end else if (!tx_en) begin
            sdo      <= 1'b0;
            underrun <= 1'b0;
            shreg    <= '0;
        end else if (load) begin
            sdo   <= aligned[WORD_W-1];
            shreg <= aligned << 1;
            if (din_valid) begin
                held <= din;
            end else begin
                underrun <= 1'b1;
            end
        end else if (shift) begin
            sdo   <= shreg[WORD_W-1];
            shreg <= shreg << 1;
        end else if (blank) begin
            sdo <= 1'b0;
        end
    end

    p_underrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && load && !din_valid) |=> underrun);
    p_underrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && underrun) |=> underrun);

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import sat_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              tx_en,
    input  logic              clk_pol,
    input  logic              data_delay,
    input  logic              fs_ignore,
    input  logic              dual_phase,
    input  logic [2:0]        wlen_a,
    input  logic [CNT_W-1:0]  wcnt_a,
    input  logic [2:0]        wlen_b,
    input  logic [CNT_W-1:0]  wcnt_b,
    input  logic [WORD_W-1:0] din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              sdo,
    output logic              sync_err,
    output logic              underrun
);
    logic             launch, sync;
    logic             load, shift, blank;
    logic [LEN_W-1:0] load_len;

    sat_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (sclk),
        .fsync   (fsync),
        .clk_pol (clk_pol),
        .launch  (launch),
        .sync    (sync)
    );

    sat_frame_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .launch    (launch),
        .sync      (sync),
        .delay1    (data_delay),
        .fs_ignore (fs_ignore),
        .two_phase (dual_phase),
        .wl_a      (wlen_a),
        .cnt_a     (wcnt_a),
        .wl_b      (wlen_b),
        .cnt_b     (wcnt_b),
        .load      (load),
        .shift     (shift),
        .blank     (blank),
        .load_len  (load_len),
        .sync_err  (sync_err)
    );

    sat_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .load      (load),
        .shift     (shift),
        .blank     (blank),
        .load_len  (load_len),
        .din       (din),
        .din_valid (din_valid),
        .sdo       (sdo),
        .underrun  (underrun)
    );

    assign din_ready = load;

    p_ready_on_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> launch);
    p_hold_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !din_ready);
    p_quiet_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sdo);
    p_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !launch) |=> $stable(sdo));

endmodule

// File: tb/serial_audio_tx_tb_top.sv
module serial_audio_tx_tb_top;
    localparam int CNT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, fsync = 1'b0, tx_en = 1'b0, clk_pol = 1'b0;
    logic data_delay = 1'b0, fs_ignore = 1'b0, dual_phase = 1'b0;
    logic [2:0] wlen_a = 3'd2, wlen_b = 3'd2;
    logic [CNT_W-1:0] wcnt_a = '0, wcnt_b = '0;
    logic [31:0] din;
    logic din_valid, din_ready, sdo, sync_err, underrun;

    logic [31:0] words [0:255];
    int idx = 0;
    int limit = 256;
    logic [31:0] mdl_prev = '0;
    logic exp_bits [0:511];
    int checks = 0, failures = 0;

    assign din       = words[idx];
    assign din_valid = (idx < limit);

    always #5 clk = ~clk;

    serial_audio_tx #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .tx_en(tx_en),
        .clk_pol(clk_pol), .data_delay(data_delay), .fs_ignore(fs_ignore),
        .dual_phase(dual_phase), .wlen_a(wlen_a), .wcnt_a(wcnt_a),
        .wlen_b(wlen_b), .wcnt_b(wcnt_b), .din(din), .din_valid(din_valid),
        .din_ready(din_ready), .sdo(sdo), .sync_err(sync_err), .underrun(underrun)
    );

    function automatic int wl_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bit period: launch edge, sample, opposite edge, sample again
    task automatic period(input logic fs_v, output logic b1, output logic b2,
                          output bit saw_ready);
        bit took;
        @(negedge clk);
        fsync = fs_v;
        sclk  = ~clk_pol;
        #1;
        took = din_ready && din_valid;
        saw_ready = din_ready;
        @(negedge clk);
        if (took) idx++;
        @(negedge clk);
        b1 = sdo;
        sclk = clk_pol;
        @(negedge clk);
        @(negedge clk);
        b2 = sdo;
    endtask

    task automatic run_frame(input int gap, input int inj, input string req);
        int n = 0;
        int start_idx = idx;
        int mi = idx;
        int bad = 0;
        int bad_p = 0;
        logic b1, b2, be;
        bit rdy;
        if (data_delay) exp_bits[n++] = 1'b0;
        for (int ph = 0; ph < (dual_phase ? 2 : 1); ph++) begin
            int wl = wl_of(ph != 0 ? wlen_b : wlen_a);
            int cnt = int'(ph != 0 ? wcnt_b : wcnt_a) + 1;
            for (int k = 0; k < cnt; k++) begin
                logic [31:0] w;
                if (mi < limit) begin
                    w = words[mi];
                    mi++;
                    mdl_prev = w;
                end else begin
                    w = mdl_prev;
                end
                for (int b = wl - 1; b >= 0; b--) exp_bits[n++] = w[b];
            end
        end
        for (int g = 0; g < gap; g++) exp_bits[n++] = 1'b0;
        for (int p = 0; p < n; p++) begin
            period((p == 0) || (inj != 0 && p == inj), b1, b2, rdy);
            if ((b1 !== exp_bits[p] || b2 !== exp_bits[p]) && bad == 0) begin
                bad_p = p;
                be = b1;
            end
            if (b1 !== exp_bits[p] || b2 !== exp_bits[p]) bad++;
        end
        chk(bad == 0, req, $sformatf("frame bit %0d", bad_p),
            32'(be), 32'(exp_bits[bad_p]));
        chk(idx - start_idx == mi - start_idx, "R11", "words consumed",
            32'(idx - start_idx), 32'(mi - start_idx));
    endtask

    task automatic disable_tx(input logic pol);
        @(negedge clk);
        tx_en = 1'b0;
        fsync = 1'b0;
        clk_pol = pol;
        sclk = pol;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic b1, b2;
        bit rdy;
        int any_out, any_rdy, start_idx;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 256; i++) words[i] = $urandom;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk(sdo == 0 && din_ready == 0, "R12", "sdo/ready after reset",
            {30'd0, sdo, din_ready}, 32'd0);
        chk(sync_err == 0 && underrun == 0, "R12", "flags after reset",
            {30'd0, sync_err, underrun}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 disabled transmitter ignores syncs and data
        any_out = 0; any_rdy = 0; start_idx = idx;
        for (int p = 0; p < 6; p++) begin
            period(p == 1 || p == 4, b1, b2, rdy);
            any_out += int'(b1) + int'(b2);
            any_rdy += int'(rdy);
        end
        chk(any_out == 0 && any_rdy == 0, "R8", "activity while disabled",
            32'(any_out + any_rdy), 32'd0);
        chk(idx == start_idx, "R8", "words taken while disabled",
            32'(idx - start_idx), 32'd0);

        tx_en = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R4 directed: 16-bit, two words, delay 0
        wlen_a = 3'd2; wcnt_a = 7'd1; dual_phase = 1'b0; data_delay = 1'b0;
        run_frame(2, 0, "R1");
        // R4 delay 1, 12-bit words
        wlen_a = 3'd1; wcnt_a = 7'd0; data_delay = 1'b1;
        run_frame(1, 0, "R4");
        // R3 two phases, 8-bit then 24-bit
        wlen_a = 3'd0; wcnt_a = 7'd1; dual_phase = 1'b1;
        wlen_b = 3'd4; wcnt_b = 7'd0; data_delay = 1'b0;
        run_frame(1, 0, "R3");
        // R5 back-to-back frame: sync on the period right after the last bit
        wlen_a = 3'd5; wcnt_a = 7'd0; dual_phase = 1'b0;
        run_frame(0, 0, "R5");
        run_frame(2, 0, "R5");

        // R2 R3 random frame shapes, rising-edge launch
        for (int f = 0; f < 10; f++) begin
            wlen_a = 3'($urandom % 6); wlen_b = 3'($urandom % 6);
            wcnt_a = 7'($urandom % 3); wcnt_b = 7'($urandom % 3);
            dual_phase = 1'($urandom % 2); data_delay = 1'($urandom % 2);
            run_frame(int'($urandom % 3), 0, "R2");
        end

        // R9 falling-edge launch
        disable_tx(1'b1);
        for (int f = 0; f < 4; f++) begin
            wlen_a = 3'($urandom % 6); wlen_b = 3'($urandom % 6);
            wcnt_a = 7'($urandom % 2); wcnt_b = 7'($urandom % 2);
            dual_phase = 1'($urandom % 2); data_delay = 1'($urandom % 2);
            run_frame(1, 0, "R9");
        end
        disable_tx(1'b0);

        // R6 sync inside frame ignored
        fs_ignore = 1'b1; dual_phase = 1'b0; wlen_a = 3'd2; wcnt_a = 7'd1;
        data_delay = 1'b0;
        run_frame(1, 6, "R6");
        chk(sync_err == 0, "R6", "sync_err with ignore", 32'(sync_err), 32'd0);

        // R7 sync inside frame flagged, sticky until disable
        fs_ignore = 1'b0;
        for (int p = 0; p < 8; p++) period(p == 0 || p == 5, b1, b2, rdy);
        chk(sync_err == 1, "R7", "sync_err after mid-frame sync",
            32'(sync_err), 32'd1);
        for (int p = 0; p < 70; p++) period(1'b0, b1, b2, rdy);
        chk(sync_err == 1, "R7", "sync_err still held", 32'(sync_err), 32'd1);
        disable_tx(1'b0);
        chk(sync_err == 0, "R7", "sync_err after disable", 32'(sync_err), 32'd0);

        // R10 underrun: second word missing, first repeats
        wlen_a = 3'd0; wcnt_a = 7'd1; data_delay = 1'b0;
        limit = idx + 1;
        run_frame(1, 0, "R10");
        chk(underrun == 1, "R10", "underrun flag", 32'(underrun), 32'd1);
        limit = 256;
        run_frame(1, 0, "R10");
        chk(underrun == 1, "R10", "underrun sticky", 32'(underrun), 32'd1);
        disable_tx(1'b0);
        chk(underrun == 0, "R10", "underrun cleared", 32'(underrun), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule